// File: doc/BRIEF.md
# Serial Management Instruction Port

This block is a bit-serial command port for management access. A host raises a frame enable and shifts an instruction in on a serial data input, one bit per clock, most significant bit first. The first four bits are an opcode. The opcode fixes how many bits make up the frame (8, 16 or 24) and how many of them a single odd parity bit covers. Once that many bits have arrived, the port checks parity and runs the command against a small local register file, a sticky status word and a diagnostic enable flag.

Each command that passes parity leaves a 17-bit answer in the low bits of the same shift register that took in the instruction. The answer is sixteen bits of command data plus an odd parity bit over them. The host does not see the answer in the frame that produced it. The answer comes out on the serial data output while the host shifts in its next instruction. A short read frame is therefore usually followed by a 16-bit no-operation frame that collects the result.

A local port lets surrounding logic write the register file directly and read it with one cycle of latency.

Top module: `smi_port`

## Requirements
- R1: After reset, sdo is 0, diag_en is 0, the status word is 0 and every register file word reads 0.
- R2: The opcode is the first four bits received. Codes and frame lengths: 0 no-op 16, 1 echo 24, 2 write 24, 3 read 8, 4 event 24, 5 clear 8, 6 status read 8, 7 diagnostic 24. Codes 8 to 15 act as no-op with 16 bits. A 24-bit frame is opcode, 3-bit address, 16-bit data MSB first, parity. An 8-bit frame is opcode, 3-bit address, parity. A 16-bit frame is opcode, 11 ignored bits, parity.
- R3: The frame is accepted only if the count of ones over all of its bits, including the parity bit received last, is odd.
- R4: The response is shifted out during the next frame, data LSB first, one bit per clock. The bit is valid before each rising edge with frame_en high. The 17th bit is odd parity over the 16 data bits. Between frames, sdo holds response bit 0.
- R5: Echo returns its data field. A no-op or undefined opcode returns zero data.
- R6: Write stores its data at its address and returns that data. Read returns the word at its address.
- R7: Event sets status bit 1 and returns its data field.
- R8: Status read returns the status word (bit 0 parity error, bit 1 event seen) and then clears it.
- R9: Clear zeroes the whole register file and the status word and returns zero data.
- R10: Diagnostic sets diag_en to data bit 0 and returns diag_en's new value in bit 0.
- R11: On a parity failure the command has no effect, status bit 0 is set, and no response is loaded. The next frame then shifts out the rejected 24-bit frame's own first 17 bits in arrival order.
- R12: Bits received after a frame completes and before frame_en falls are ignored. A frame that ends early executes nothing.
- R13: A local write takes effect when no serial write or clear executes in the same cycle. A local read returns the addressed word one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_en | input | 1 | High for the duration of one instruction frame |
| sdi | input | 1 | Serial instruction data, MSB first |
| sdo | output | 1 | Serial response data, LSB first |
| loc_we | input | 1 | Local register file write enable |
| loc_addr | input | 3 | Local register file address |
| loc_wdata | input | 16 | Local register file write data |
| loc_rdata | output | 16 | Local register file read data, one cycle after address |
| diag_en | output | 1 | Diagnostic enable flag set by the diagnostic command |

## Verification
The bench runs every one of the sixteen opcodes at its exact frame length. A port that counted a frame wrong would either never execute it or would run it too early and fail parity, so the next response would not hold the expected zero or echo data. Response bits are collected position by position, which exposes a reversed shift order or a parity bit in the wrong place or of the wrong sense. Rejected frames are checked three ways: the next frame must return the raw instruction bits, the status word must show the flag, and a rejected write or clear must leave the register file intact. Trailing extra bits and truncated frames are also driven, since a port that kept shifting after completion, or executed on a short frame, would corrupt the stored answer or the register file.

// File: rtl/smi_pkg.sv
package smi_pkg;

  localparam int unsigned OPW = 4;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ECHO = 4'd1,
    OP_WR   = 4'd2,
    OP_RD   = 4'd3,
    OP_EVT  = 4'd4,
    OP_CLR  = 4'd5,
    OP_STAT = 4'd6,
    OP_DIAG = 4'd7
  } op_e;

  localparam int unsigned ST_PERR = 0;
  localparam int unsigned ST_EVT  = 1;

  // Frame length in bits for a given opcode
  function automatic int unsigned frame_bits(input logic [3:0] op,
                                             input int unsigned dw,
                                             input int unsigned aw);
    case (op)
      OP_ECHO, OP_WR, OP_EVT, OP_DIAG: return OPW + aw + dw + 1;
      OP_RD, OP_CLR, OP_STAT:          return OPW + aw + 1;
      default:                         return dw;
    endcase
  endfunction

endpackage

// File: rtl/smi_frame.sv
module smi_frame #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_en,
  input  logic          sdi,
  input  logic [DW:0]   resp_word,
  output logic          exec_stb,
  output logic          par_ok,
  output logic [3:0]    op_q,
  output logic [AW-1:0] fld_addr,
  output logic [DW-1:0] fld_data,
  output logic          sdo
);
  import smi_pkg::*;

  localparam int unsigned IW = OPW + AW + DW + 1;
  localparam int unsigned RW = DW + 1;
  localparam int unsigned CW = $clog2(IW + 1);

  logic [IW-1:0] sr_q, sr_nx, ins_rev, cov_mask;
  logic [CW-1:0] cnt_q, cnt_inc, len;
  logic          done_q, shift, long_fmt;

  assign shift   = frame_en && !done_q;
  assign sr_nx   = {sdi, sr_q[IW-1:1]};
  assign cnt_inc = cnt_q + 1'b1;
  assign len     = CW'(frame_bits(op_q, DW, AW));

  // first received bit ends up in the highest covered position
  always_comb begin
    for (int i = 0; i < IW; i++) ins_rev[i] = sr_nx[IW-1-i];
  end

  assign cov_mask = {IW{1'b1}} >> (CW'(IW) - len);
  assign par_ok   = ^(ins_rev & cov_mask);
  assign long_fmt = (len == CW'(IW));
  assign fld_addr = long_fmt ? ins_rev[IW-OPW-1 -: AW] : ins_rev[AW:1];
  assign fld_data = ins_rev[DW:1];
  assign exec_stb = shift && (cnt_q >= CW'(OPW)) && (cnt_inc == len);
  assign sdo      = sr_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      op_q   <= '0;
    end else if (!frame_en) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      cnt_q <= cnt_inc;
      if (cnt_inc == CW'(OPW)) op_q <= ins_rev[OPW-1:0];
      if (exec_stb) begin
        done_q <= 1'b1;
        sr_q   <= par_ok ? {sr_nx[IW-1:RW], resp_word} : sr_nx;
      end else begin
        sr_q <= sr_nx;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(IW)); // R12
  AST_ONE_EXEC: assert property (@(posedge clk) disable iff (rst)
    exec_stb |=> !exec_stb); // R12
  AST_SDO_IDLE: assert property (@(posedge clk) disable iff (rst)
    !frame_en |=> $stable(sdo)); // R4

endmodule

// File: rtl/smi_regs.sv
module smi_regs #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          s_we,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_wdata,
  output logic [DW-1:0] s_rdata,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  assign s_rdata = mem[s_addr];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (s_we) begin
      mem[s_addr] <= s_wdata;
    end else if (l_we) begin
      mem[l_addr] <= l_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) l_rdata <= '0;
    else     l_rdata <= mem[l_addr];
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr |=> (mem[$past(l_addr)] == '0)); // R9

endmodule

// File: rtl/smi_port.sv
module smi_port #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_en,
  input  logic          sdi,
  output logic          sdo,
  input  logic          loc_we,
  input  logic [AW-1:0] loc_addr,
  input  logic [DW-1:0] loc_wdata,
  output logic [DW-1:0] loc_rdata,
  output logic          diag_en
);
  import smi_pkg::*;

  logic          exec_stb, par_ok, good;
  logic [3:0]    op_q;
  logic [AW-1:0] fld_addr;
  logic [DW-1:0] fld_data, rd_data, resp_data, stat_q;
  logic [DW:0]   resp_word;
  logic          diag_q;

  smi_frame #(.DW(DW), .AW(AW)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .frame_en (frame_en),
    .sdi      (sdi),
    .resp_word(resp_word),
    .exec_stb (exec_stb),
    .par_ok   (par_ok),
    .op_q     (op_q),
    .fld_addr (fld_addr),
    .fld_data (fld_data),
    .sdo      (sdo)
  );

  assign good = exec_stb && par_ok;

  smi_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .clr    (good && (op_q == OP_CLR)),
    .s_we   (good && (op_q == OP_WR)),
    .s_addr (fld_addr),
    .s_wdata(fld_data),
    .s_rdata(rd_data),
    .l_we   (loc_we),
    .l_addr (loc_addr),
    .l_wdata(loc_wdata),
    .l_rdata(loc_rdata)
  );

  always_comb begin
    case (op_q)
      OP_ECHO, OP_WR, OP_EVT: resp_data = fld_data;
      OP_RD:                  resp_data = rd_data;
      OP_STAT:                resp_data = stat_q;
      OP_DIAG:                resp_data = {{(DW-1){1'b0}}, fld_data[0]};
      default:                resp_data = '0;
    endcase
  end

  assign resp_word = {~^resp_data, resp_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      diag_q <= 1'b0;
    end else if (exec_stb) begin
      if (!par_ok) begin
        stat_q[ST_PERR] <= 1'b1;
      end else begin
        case (op_q)
          OP_EVT:          stat_q[ST_EVT] <= 1'b1;
          OP_STAT, OP_CLR: stat_q <= '0;
          OP_DIAG:         diag_q <= fld_data[0];
          default:         ;
        endcase
      end
    end
  end

  assign diag_en = diag_q;

  AST_PERR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (exec_stb && !par_ok) |=> stat_q[ST_PERR]); // R11
  AST_DIAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !exec_stb |=> $stable(diag_en)); // R10
  AST_PERR_DIAG: assert property (@(posedge clk) disable iff (rst)
    (exec_stb && !par_ok) |=> $stable(diag_en)); // R11

endmodule

// File: tb/smi_port_bench.sv
module smi_port_bench;
  import smi_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_en = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo;
  logic        loc_we = 1'b0;
  logic [2:0]  loc_addr = '0;
  logic [15:0] loc_wdata = '0;
  logic [15:0] loc_rdata;
  logic        diag_en;

  int nchk = 0;
  int nfail = 0;
  logic [31:0] got;

  always #10 clk = ~clk;

  smi_port u_smi_port (
    .clk(clk), .rst(rst), .frame_en(frame_en), .sdi(sdi), .sdo(sdo),
    .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata), .diag_en(diag_en)
  );

  function automatic logic [31:0] mk_long(logic [3:0] op, logic [2:0] a,
                                          logic [15:0] d, bit bad);
    logic [22:0] b = {op, a, d};
    return {9'h0, b} << 1 | 32'((~^b) ^ bad);
  endfunction

  function automatic logic [31:0] mk_short(logic [3:0] op, logic [2:0] a, bit bad);
    logic [6:0] b = {op, a};
    return {24'h0, b, (~^b) ^ bad};
  endfunction

  function automatic logic [31:0] mk_nop(logic [3:0] op);
    logic [14:0] b = {op, 11'h0};
    return {16'h0, b, ~^b};
  endfunction

  function automatic logic [15:0] pat(int a);
    return 16'((a + 1) * 16'h1357) ^ 16'h8421;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [31:0] bits, int n);
    got = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      frame_en = 1'b1;
      sdi = bits[n-1-k];
      #1 got[k] = sdo;
    end
    @(negedge clk);
    frame_en = 1'b0;
    sdi = 1'b0;
  endtask

  task automatic loc_read(logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    loc_addr = a;
    @(negedge clk);
    v = loc_rdata;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [31:0] bad, exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 sdo", 32'(sdo), 0);
    chk("R1 diag_en", 32'(diag_en), 0);
    for (int a = 0; a < 8; a++) begin
      loc_read(3'(a), v);
      chk("R1 regfile", 32'(v), 0);
    end
    send(mk_short(OP_STAT, 0, 0), 8);
    send(mk_nop(OP_NOP), 16);
    chk("R1 status", 32'(got[15:0]), 0);

    // R3 R4 R5 echo patterns, data LSB first then parity
    send(mk_long(OP_ECHO, 0, 16'hA5C3, 0), 24);
    for (int p = 0; p < 5; p++) begin
      logic [15:0] prev, d;
      prev = (p == 0) ? 16'hA5C3 : 16'((p - 1) * 16'h3B71 + (p == 1 ? 16'hFFFF : 0));
      d = 16'(p * 16'h3B71 + (p == 0 ? 16'hFFFF : 0));
      send(mk_long(OP_ECHO, 0, d, 0), 24);
      chk("R4 R5 echo data", 32'(got[15:0]), 32'(prev));
      chk("R4 response parity", 32'(got[16]), 32'(~^prev));
    end
    chk("R4 idle sdo holds bit0", 32'(sdo), 32'(16'(4 * 16'h3B71) & 16'h1));

    // R2 R5 no-op and undefined opcodes: 16-bit frames, zero data
    for (int op = 0; op < 16; op++) begin
      if (op >= 1 && op <= 7) continue;
      send(mk_long(OP_ECHO, 0, 16'hFFFF, 0), 24);
      send(mk_nop(4'(op)), 16);
      chk("R2 nop frame collects", 32'(got[15:0]), 32'hFFFF);
      send(mk_long(OP_ECHO, 0, 16'h0, 0), 24);
      chk("R5 nop response zero", 32'(got[16:0]), 32'h10000);
    end

    // R6 R2 write and read sweep, R13 local read
    for (int a = 0; a < 8; a++) begin
      send(mk_long(OP_WR, 3'(a), pat(a), 0), 24);
      send(mk_short(OP_RD, 3'(a), 0), 8);
      chk("R6 write response", 32'(got[7:0]), 32'(pat(a) & 16'hFF));
      send(mk_nop(OP_NOP), 16);
      chk("R6 read data", 32'(got[15:0]), 32'(pat(a)));
      loc_read(3'(a), v);
      chk("R13 local read", 32'(v), 32'(pat(a)));
    end

    // R12 trailing bits ignored
    send((mk_long(OP_ECHO, 0, 16'h6D2B, 0) << 5) | 32'h16, 29);
    chk("R12 idle sdo after extra bits", 32'(sdo), 1);
    send(mk_nop(OP_NOP), 16);
    chk("R12 extra bits ignored", 32'(got[15:0]), 32'h6D2B);

    // R12 truncated write frame executes nothing
    send(mk_long(OP_WR, 5, 16'h9999, 0) >> 4, 20);
    send(mk_short(OP_RD, 5, 0), 8);
    send(mk_nop(OP_NOP), 16);
    chk("R12 short frame no write", 32'(got[15:0]), 32'(pat(5)));

    // R13 local write
    @(negedge clk);
    loc_we = 1'b1; loc_addr = 3; loc_wdata = 16'hBEEF;
    @(negedge clk);
    loc_we = 1'b0;
    send(mk_short(OP_RD, 3, 0), 8);
    send(mk_nop(OP_NOP), 16);
    chk("R13 local write seen serially", 32'(got[15:0]), 32'hBEEF);

    // R7 R8 event and status read
    send(mk_long(OP_EVT, 0, 16'h0F0F, 0), 24);
    send(mk_short(OP_STAT, 0, 0), 8);
    chk("R7 event response", 32'(got[7:0]), 32'h0F);
    send(mk_nop(OP_NOP), 16);
    chk("R7 R8 event status bit", 32'(got[15:0]), 32'h0002);
    send(mk_short(OP_STAT, 0, 0), 8);
    send(mk_nop(OP_NOP), 16);
    chk("R8 status cleared by read", 32'(got[15:0]), 0);

    // R11 parity failure on echo: raw bits come back
    bad = mk_long(OP_ECHO, 0, 16'h3C3C, 1);
    send(bad, 24);
    send(mk_long(OP_ECHO, 0, 16'h0, 0), 24);
    exp = '0;
    for (int k = 0; k < 17; k++) exp[k] = bad[23-k];
    chk("R11 R3 raw bits returned", 32'(got[16:0]), exp);
    send(mk_short(OP_STAT, 0, 0), 8);
    send(mk_nop(OP_NOP), 16);
    chk("R11 status perr", 32'(got[15:0]), 32'h0001);

    // R11 rejected write leaves register file
    send(mk_long(OP_WR, 2, 16'h7777, 1), 24);
    loc_read(2, v);
    chk("R11 rejected write", 32'(v), 32'(pat(2)));

    // R10 diagnostic
    send(mk_long(OP_DIAG, 0, 16'hFFF1, 0), 24);
    chk("R10 diag set", 32'(diag_en), 1);
    send(mk_nop(OP_NOP), 16);
    chk("R10 diag response", 32'(got[15:0]), 32'h0001);
    send(mk_long(OP_DIAG, 0, 16'h0001, 1), 24);
    chk("R11 rejected diag", 32'(diag_en), 1);
    send(mk_long(OP_DIAG, 0, 16'hFFFE, 0), 24);
    chk("R10 diag clear", 32'(diag_en), 0);
    send(mk_nop(OP_NOP), 16);
    chk("R10 diag response zero", 32'(got[15:0]), 0);

    // R11 rejected clear, then R9 clear
    send(mk_short(OP_CLR, 0, 1), 8);
    loc_read(4, v);
    chk("R11 rejected clear", 32'(v), 32'(pat(4)));
    send(mk_long(OP_EVT, 0, 16'h1234, 0), 24);
    send(mk_short(OP_CLR, 0, 0), 8);
    send(mk_nop(OP_NOP), 16);
    chk("R9 clear response", 32'(got[15:0]), 0);
    for (int a = 0; a < 8; a++) begin
      loc_read(3'(a), v);
      chk("R9 regfile cleared", 32'(v), 0);
    end
    send(mk_short(OP_STAT, 0, 0), 8);
    send(mk_nop(OP_NOP), 16);
    chk("R9 status cleared", 32'(got[15:0]), 0);

    finish_run();
  end

endmodule